// File: doc/BRIEF.md
# Teletext Bit Request Receiver

This block is the input side of a teletext path that pulls its data one bit at a time from an external source. When the window-mode control is low (pulsed mode), it raises a one-cycle request strobe on each line marked for teletext. The strobe rate comes from a fractional phase accumulator, and the increment sets the bit rate of the chosen teletext system as a fraction of the pixel clock.

An external source answers each request after some latency. The block absorbs that latency with a programmable input delay of 0 to 15 clocks. At the chosen clock edge after the request it samples the serial data pin and places the bit in an eight-entry buffer. The downstream modulator drains the buffer one bit at a time. If the modulator falls behind, a sticky flag records the loss.

Top module: `ttx_bit_pull`

## Requirements
- R1: After reset, `bit_req`, `rd_valid` and `ovf` are 0 and `fill` is 0.
- R2: Requests are issued only while `win_mode` is 0 and `line_en` is 1. One clock after either condition is sampled false, `bit_req` is low and the accumulator is cleared to zero.
- R3: On each enabled clock edge, an ACC_W-bit accumulator adds `rate_inc`. A carry out makes `bit_req` high for exactly the following cycle. Over N enabled edges starting from a cleared accumulator, the design issues floor(N*rate_inc/2^ACC_W) requests. `rate_inc` must not exceed 2^(ACC_W-1).
- R4: Each rising edge of `bit_req` causes one sample of `ttx_in`. With an `in_dly` value of d (0 to 15), the sample is taken at the d-th clock edge after the first edge at which `bit_req` is seen high. For d = 0, the sample is taken at that first edge itself.
- R5: Captured bits leave in capture order. `rd_bit` shows the oldest bit, and `rd_valid` is high while the buffer holds at least one bit. `rd_en` with `rd_valid` removes one bit at the clock edge.
- R6: `fill` reports the number of held bits, from 0 to 8. `rd_en` while the buffer is empty has no effect.
- R7: When a bit is captured while 8 bits are held and no bit is removed in the same cycle, the bit is dropped and `ovf` is set. `ovf` stays set until reset. When a capture and a removal coincide while the buffer is full, the capture is accepted.
- R8: A request that is still waiting out its input delay when the line ends is still captured at its scheduled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_mode | input | 1 | 0 selects pulsed request mode, 1 suppresses requests |
| line_en | input | 1 | High on lines that carry teletext |
| rate_inc | input | ACC_W | Accumulator increment per clock |
| in_dly | input | DLY_W | Input delay, in clocks, from request to sample |
| ttx_in | input | 1 | Serial teletext data pin |
| rd_en | input | 1 | Modulator removes the oldest bit |
| bit_req | output | 1 | One-cycle bit request strobe |
| rd_valid | output | 1 | Buffer is not empty |
| rd_bit | output | 1 | Oldest buffered bit |
| fill | output | $clog2(FIFO_DEPTH)+1 | Number of buffered bits |
| ovf | output | 1 | Sticky overflow flag |

## Verification
`bit_req` follows a carry one clock later, and it falls one clock after the enable is sampled false. A captured bit shows in `fill` and `rd_valid` one clock after its sampling edge. That edge lies `in_dly` edges after the first edge at which the request is high. A removal shows one clock after the edge at which `rd_en` is sampled. The bench updates a behavioural model on every rising edge from the inputs that edge samples. It compares all outputs at the following falling edge, so each result is checked in the cycle it is due. Request counts over whole lines are checked against the floor formula of R3.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  // Single-cycle rising edge from a level and its registered copy.
  function automatic logic edge_up(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  // Full condition of a buffer whose occupancy is counted.
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return cnt == lim;
  endfunction
endpackage

// File: rtl/ttx_rate_gen.sv
module ttx_rate_gen #(
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [ACC_W-1:0] rate_inc,
  output logic             req_q,
  output logic             req_rise
);
  import ttx_pkg::*;

  logic [ACC_W-1:0] acc;
  logic             req_d;
  logic [ACC_W:0]   sum;

  function automatic logic [ACC_W:0] acc_add(input logic [ACC_W-1:0] a,
                                             input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum      = acc_add(acc, rate_inc);
  assign req_rise = edge_up(req_q, req_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      req_q <= 1'b0;
      req_d <= 1'b0;
    end else begin
      req_d <= req_q;
      if (active) begin
        acc   <= sum[ACC_W-1:0];
        req_q <= sum[ACC_W];
      end else begin
        acc   <= '0;
        req_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ttx_cap_dly.sv
module ttx_cap_dly #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_rise,
  input  logic [DLY_W-1:0] in_dly,
  output logic             cap_fire
);
  localparam int SPAN = 1 << DLY_W;

  logic [SPAN-2:0] hist;
  logic [SPAN-1:0] taps;

  assign taps     = {hist, req_rise};
  assign cap_fire = taps[in_dly];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= taps[SPAN-2:0];
  end
endmodule

// File: rtl/ttx_bit_fifo.sv
module ttx_bit_fifo #(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic                     din,
  input  logic                     rd_en,
  output logic                     pop,
  output logic                     dout,
  output logic                     nonempty,
  output logic [$clog2(DEPTH):0]   cnt,
  output logic                     ovf
);
  import ttx_pkg::*;
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wptr, rptr;
  logic             full, wr, lost;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (cnt != '0);
  assign full     = at_limit(int'(cnt), DEPTH);
  assign pop      = rd_en & nonempty;
  assign wr       = push & (~full | pop);
  assign lost     = push & full & ~pop;
  assign dout     = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem  <= '0;
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr) begin
        mem[wptr] <= din;
        wptr      <= ptr_next(wptr);
      end
      if (pop) rptr <= ptr_next(rptr);
      if (wr && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !wr) cnt <= cnt - 1'b1;
      if (lost) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/ttx_bit_pull.sv
module ttx_bit_pull #(
  parameter int ACC_W      = 12,
  parameter int DLY_W      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          win_mode,
  input  logic                          line_en,
  input  logic [ACC_W-1:0]              rate_inc,
  input  logic [DLY_W-1:0]              in_dly,
  input  logic                          ttx_in,
  input  logic                          rd_en,
  output logic                          bit_req,
  output logic                          rd_valid,
  output logic                          rd_bit,
  output logic [$clog2(FIFO_DEPTH):0]   fill,
  output logic                          ovf
);
  // Named internal events, exposed for the checker.
  logic active;
  logic req_rise;
  logic cap_fire;
  logic pop;

  assign active = line_en & ~win_mode;

  ttx_rate_gen #(.ACC_W(ACC_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .active(active), .rate_inc(rate_inc),
    .req_q(bit_req), .req_rise(req_rise)
  );

  ttx_cap_dly #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .req_rise(req_rise), .in_dly(in_dly),
    .cap_fire(cap_fire)
  );

  ttx_bit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(cap_fire), .din(ttx_in), .rd_en(rd_en),
    .pop(pop), .dout(rd_bit), .nonempty(rd_valid), .cnt(fill), .ovf(ovf)
  );
endmodule

// File: rtl/ttx_bit_pull_chk.sv
module ttx_bit_pull_chk #(
  parameter int FIFO_DEPTH = 8,
  parameter int DLY_W      = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        active,
  input logic                        bit_req,
  input logic                        req_rise,
  input logic                        cap_fire,
  input logic                        pop,
  input logic [DLY_W-1:0]            in_dly,
  input logic [$clog2(FIFO_DEPTH):0] fill,
  input logic                        ovf
);
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !bit_req); // R2
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> !bit_req); // R3
  AST_ZERO_DELAY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && in_dly == '0) |-> cap_fire); // R4
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !pop && int'(fill) < FIFO_DEPTH) |=> int'(fill) == int'($past(fill)) + 1); // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= FIFO_DEPTH); // R6
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0 && !cap_fire) |=> fill == '0); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R7
endmodule

bind ttx_bit_pull ttx_bit_pull_chk #(.FIFO_DEPTH(FIFO_DEPTH), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .bit_req(bit_req),
  .req_rise(req_rise), .cap_fire(cap_fire), .pop(pop), .in_dly(in_dly),
  .fill(fill), .ovf(ovf)
);

// File: tb/sim_ttx_bit_pull.sv
module sim_ttx_bit_pull;
  localparam int ACC_W = 12;
  localparam int DLY_W = 4;
  localparam int DEPTH = 8;
  localparam int MOD   = 1 << ACC_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_mode = 1'b0, line_en = 1'b0, ttx_in = 1'b0, rd_en = 1'b0;
  logic [ACC_W-1:0] rate_inc = '0;
  logic [DLY_W-1:0] in_dly = '0;
  logic bit_req, rd_valid, rd_bit, ovf;
  logic [$clog2(DEPTH):0] fill;

  always #10 clk = ~clk;

  ttx_bit_pull #(.ACC_W(ACC_W), .DLY_W(DLY_W), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .win_mode(win_mode), .line_en(line_en),
    .rate_inc(rate_inc), .in_dly(in_dly), .ttx_in(ttx_in), .rd_en(rd_en),
    .bit_req(bit_req), .rd_valid(rd_valid), .rd_bit(rd_bit), .fill(fill), .ovf(ovf)
  );

  int vectors = 0, errors = 0, req_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  // Behavioural reference model.
  int m_acc;
  bit m_req, m_req_d, m_ovf;
  bit rq[$];
  bit fq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_req = 0; m_req_d = 0; m_ovf = 0;
      rq.delete(); fq.delete();
    end else begin
      bit rise, cap, rem;
      int s, d;
      rise = m_req && !m_req_d;
      d = int'(in_dly);
      if (d == 0) cap = rise;
      else        cap = (rq.size() >= d) ? rq[d-1] : 1'b0;
      rem = rd_en && (fq.size() > 0);
      if (rem) void'(fq.pop_front());
      if (cap) begin
        if (fq.size() < DEPTH) fq.push_back(ttx_in);
        else m_ovf = 1;
      end
      rq.push_front(rise);
      if (rq.size() > 16) void'(rq.pop_back());
      m_req_d = m_req;
      if (line_en && !win_mode) begin
        s = m_acc + int'(rate_inc);
        m_req = (s >= MOD);
        m_acc = s % MOD;
      end else begin
        m_acc = 0; m_req = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare at the falling edge, then drive the next inputs.
  task automatic step(input bit le, input bit rd);
    @(negedge clk);
    if (rst_n) begin
      chk("R3 bit_req", int'(bit_req), int'(m_req));
      chk("R5 rd_valid", int'(rd_valid), int'(fq.size() > 0));
      if (fq.size() > 0) chk("R4 rd_bit", int'(rd_bit), int'(fq[0]));
      chk("R6 fill", int'(fill), fq.size());
      chk("R7 ovf", int'(ovf), int'(m_ovf));
    end
    if (bit_req) req_seen++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ttx_in  = lfsr[0];
    line_en = le;
    rd_en   = rd;
  endtask

  task automatic segment(input int n, input int rd_period, input int exp_req, input string tag);
    req_seen = 0;
    for (int i = 0; i < n; i++) step(1'b1, (i % rd_period) == 0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    chk(tag, req_seen, exp_req);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 bit_req", int'(bit_req), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    chk("R1 fill", int'(fill), 0);
    chk("R1 ovf", int'(ovf), 0);

    // R3 integer rate, zero delay, reader always ready
    in_dly = 4'd0; rate_inc = 12'd1024;
    segment(200, 1, 50, "R3 count inc1024");
    // R4/R8 fractional rate, mid delay, slower reader
    in_dly = 4'd7; rate_inc = 12'd700;
    segment(300, 2, 51, "R3 count inc700");
    // R4/R8 maximum delay, densest legal rate
    in_dly = 4'd15; rate_inc = 12'd2048;
    segment(150, 3, 75, "R3 count inc2048");
    // R2 window mode suppresses requests
    win_mode = 1'b1;
    segment(150, 1, 0, "R2 window mode count");
    chk("R2 fill after window", int'(fill), 0);
    win_mode = 1'b0;

    // R7 overflow with no reader
    in_dly = 4'd3; rate_inc = 12'd1024;
    req_seen = 0;
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0);
    chk("R7 ovf set", int'(ovf), 1);
    chk("R7 fill full", int'(fill), DEPTH);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1);
    chk("R7 ovf sticky", int'(ovf), 1);
    chk("R6 drained", int'(fill), 0);
    // R6 reads on empty buffer
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    chk("R6 empty read", int'(fill), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule